// File: doc/BRIEF.md
# Masked Vector Doubleword-to-Halfword Narrowing Unit

This block narrows a 512-bit source vector of 32-bit lanes into packed 16-bit lanes. It has three conversion modes: plain truncation, signed saturation and unsigned saturation. A vector-length select sets how many lanes take part: 4, 8 or 16. Each lane can be enabled by a writemask. A lane that is not enabled either keeps the previous destination word (merging) or is cleared (zeroing).

The destination is either a register or memory. For a register, every bit above the packed result is cleared, and no store byte-enables are raised. For memory, lanes that are not enabled are always preserved, and per-byte store enables mark the words that should be written. A reserved 4-bit operand field must be all ones. If it is not, or if the mode or length code is unused, the block flags an invalid encoding and suppresses the result.

The block captures its inputs on a valid strobe and presents the registered result one cycle later.

Top module: `vec_narrow_unit`

## Requirements
- R1: `vlen_sel` chooses the active lane count KL: 2'b00 gives 4 lanes, 2'b01 gives 8 and 2'b10 gives 16. Code 2'b11 is an invalid encoding.
- R2: Lane j reads `src[32j+31:32j]` and produces `result[16j+15:16j]`, so words are packed upward from bit 0.
- R3: Mode 2'b00 (truncate) yields the low 16 bits of the lane.
- R4: Mode 2'b01 (signed saturate) reads the lane as two's complement. Values above 32767 give 16'h7FFF, values below -32768 give 16'h8000, and other values give their low 16 bits.
- R5: Mode 2'b10 (unsigned saturate) reads the lane as unsigned. Values above 65535 give 16'hFFFF, and other values give their low 16 bits.
- R6: An active lane is written when `mask_en` is 0 or its `mask` bit is 1. Otherwise, with a register destination, it takes the matching `old_dest` word when `zero_mask`=0 and zero when `zero_mask`=1.
- R7: With a register destination (`dest_mem`=0), `result` bits from 16*KL up to 511 are zero and `byte_en` is all zero.
- R8: With a memory destination (`dest_mem`=1), lanes that are not enabled take their `old_dest` word whatever `zero_mask` says. Bits from 16*KL up to 511 also take `old_dest`. Bits `byte_en[2j+1:2j]` are both 1 exactly when lane j is active and enabled, and 0 otherwise.
- R9: If `rsvd_field` is not 4'b1111, or `mode` is 2'b11, or `vlen_sel` is 2'b11, then `bad_enc` is 1 and both `result` and `byte_en` are zero. Otherwise `bad_enc` is 0.
- R10: `mask` bits at index KL and above have no effect on any output.
- R11: `out_valid` equals `in_valid` delayed by one clock. `result`, `byte_en` and `bad_enc` load only in a cycle where `in_valid` is high, and hold otherwise. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe; inputs are captured on this cycle |
| src | input | 512 | Source vector of 32-bit lanes |
| vlen_sel | input | 2 | Vector length code |
| mode | input | 2 | Conversion mode code |
| mask | input | 16 | Per-lane writemask |
| mask_en | input | 1 | 1 applies the writemask, 0 enables every active lane |
| zero_mask | input | 1 | 1 zeroes lanes that are not enabled (register destination only) |
| dest_mem | input | 1 | 1 selects a memory destination |
| old_dest | input | 512 | Previous destination contents used for merging |
| rsvd_field | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 512 | Narrowed and masked destination value |
| byte_en | output | 32 | Store byte-enables, two per 16-bit word |
| bad_enc | output | 1 | Invalid encoding flag |

## Verification
Saturation and masking can both act on the same lane in the same cycle. Lane-length clipping and destination type also act together: a memory operation with a short vector must both preserve masked-off lanes and preserve the words above the active length. The bench provokes these overlaps by drawing random source values that are biased toward the clamp thresholds. These values are combined with random masks, mask bits set above the active length, both destination kinds and both masking styles. Each case is judged against a word-by-word model in the bench, on both `result` and `byte_en`. Directed cases pin the exact threshold values 32767/32768, -32768/-32769 and 65535/65536.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  localparam int DW_W = 32;
  localparam int HW_W = 16;

  typedef enum logic [1:0] {
    NM_TRUNC = 2'b00,
    NM_SSAT  = 2'b01,
    NM_USAT  = 2'b10,
    NM_RSVD  = 2'b11
  } narrow_mode_e;

  // Signed clamp of a 32-bit value into a 16-bit word
  function automatic logic [HW_W-1:0] clamp_signed(input logic [DW_W-1:0] v);
    logic hi_all0, hi_all1;
    hi_all0 = (v[DW_W-1:HW_W-1] == '0);
    hi_all1 = (v[DW_W-1:HW_W-1] == '1);
    if (!hi_all0 && !hi_all1)
      clamp_signed = v[DW_W-1] ? {1'b1, {(HW_W-1){1'b0}}} : {1'b0, {(HW_W-1){1'b1}}};
    else
      clamp_signed = v[HW_W-1:0];
  endfunction

  // Unsigned clamp of a 32-bit value into a 16-bit word
  function automatic logic [HW_W-1:0] clamp_unsigned(input logic [DW_W-1:0] v);
    clamp_unsigned = (v[DW_W-1:HW_W] != '0) ? '1 : v[HW_W-1:0];
  endfunction
endpackage

// File: rtl/narrow_lane.sv
module narrow_lane
  import narrow_pkg::*;
(
  input  logic [DW_W-1:0] lane_in,
  input  narrow_mode_e    mode,
  output logic [HW_W-1:0] lane_out
);
  always_comb begin
    unique case (mode)
      NM_SSAT: lane_out = clamp_signed(lane_in);
      NM_USAT: lane_out = clamp_unsigned(lane_in);
      default: lane_out = lane_in[HW_W-1:0];
    endcase
  end
endmodule

// File: rtl/narrow_lane_select.sv
module narrow_lane_select #(
  parameter int LANES = 16
) (
  input  logic [1:0]       vlen_sel,
  input  logic [LANES-1:0] mask,
  input  logic             mask_en,
  output logic [LANES-1:0] lane_active,
  output logic [LANES-1:0] lane_on,
  output logic             vlen_ok
);
  localparam int MIN_LANES = LANES / 4;

  logic [$clog2(LANES+1)-1:0] act_cnt;

  always_comb begin
    vlen_ok = (vlen_sel != 2'b11);
    act_cnt = vlen_ok ? ($clog2(LANES+1))'(MIN_LANES << vlen_sel) : '0;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_active[j] = (j < int'(act_cnt));
    assign lane_on[j]     = lane_active[j] && (!mask_en || mask[j]);
  end
endmodule

// File: rtl/vec_narrow_unit.sv
module vec_narrow_unit
  import narrow_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*32-1:0]   src,
  input  logic [1:0]            vlen_sel,
  input  logic [1:0]            mode,
  input  logic [LANES-1:0]      mask,
  input  logic                  mask_en,
  input  logic                  zero_mask,
  input  logic                  dest_mem,
  input  logic [LANES*32-1:0]   old_dest,
  input  logic [3:0]            rsvd_field,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   result,
  output logic [LANES*2-1:0]    byte_en,
  output logic                  bad_enc
);
  localparam int VEC_W = LANES * DW_W;
  localparam int PK_W  = LANES * HW_W;
  localparam int BE_W  = PK_W / 8;
  localparam int BPW   = HW_W / 8;

  narrow_mode_e           mode_e;
  logic [LANES-1:0]       lane_active, lane_on;
  logic                   vlen_ok;
  logic                   enc_bad;
  logic [HW_W-1:0]        conv [LANES];
  logic [VEC_W-1:0]       nxt_result;
  logic [BE_W-1:0]        nxt_be;

  assign mode_e  = narrow_mode_e'(mode);
  assign enc_bad = (rsvd_field != 4'b1111) || (mode_e == NM_RSVD) || !vlen_ok;

  narrow_lane_select #(.LANES(LANES)) u_sel (
    .vlen_sel   (vlen_sel),
    .mask       (mask),
    .mask_en    (mask_en),
    .lane_active(lane_active),
    .lane_on    (lane_on),
    .vlen_ok    (vlen_ok)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_conv
    narrow_lane u_lane (
      .lane_in (src[j*DW_W +: DW_W]),
      .mode    (mode_e),
      .lane_out(conv[j])
    );

    // R4 signed clamp at the lane output
    assert_ssat_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == NM_SSAT && $signed(src[j*DW_W +: DW_W]) > 32767) |-> conv[j] == 16'h7FFF);
    // R5 unsigned clamp at the lane output
    assert_usat_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == NM_USAT && src[j*DW_W+HW_W +: HW_W] != '0) |-> conv[j] == 16'hFFFF);
  end

  always_comb begin
    nxt_result = '0;
    nxt_be     = '0;
    if (!enc_bad) begin
      for (int j = 0; j < LANES; j++) begin
        if (lane_on[j])
          nxt_result[j*HW_W +: HW_W] = conv[j];
        else if (dest_mem || (lane_active[j] && !zero_mask))
          nxt_result[j*HW_W +: HW_W] = old_dest[j*HW_W +: HW_W];
        if (dest_mem && lane_on[j])
          nxt_be[j*BPW +: BPW] = '1;
      end
      if (dest_mem)
        nxt_result[VEC_W-1:PK_W] = old_dest[VEC_W-1:PK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      byte_en   <= '0;
      bad_enc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_result;
        byte_en <= nxt_be;
        bad_enc <= enc_bad;
      end
    end
  end

  // R11 valid latency
  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11 hold when idle
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(byte_en));
  // R9 suppression on bad encoding
  assert_bad_suppress_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_enc |-> (result == '0 && byte_en == '0));
  // R7 register destination raises no store enables and clears the upper half
  assert_reg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dest_mem) |-> (nxt_be == '0 && nxt_result[VEC_W-1:PK_W] == '0));
  // R8 store enables come in whole-word pairs tied to enabled lanes
  for (genvar j = 0; j < LANES; j++) begin : g_be_chk
    assert_be_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (nxt_be[j*BPW +: BPW] == (lane_on[j] && dest_mem && !enc_bad ? {BPW{1'b1}} : {BPW{1'b0}})));
  end
endmodule

// File: tb/vec_narrow_unit_test.sv
module vec_narrow_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [1:0]   vlen_sel = '0;
  logic [1:0]   mode = '0;
  logic [15:0]  mask = '0;
  logic         mask_en = 1'b0;
  logic         zero_mask = 1'b0;
  logic         dest_mem = 1'b0;
  logic [511:0] old_dest = '0;
  logic [3:0]   rsvd_field = 4'hF;
  logic         out_valid;
  logic [511:0] result;
  logic [31:0]  byte_en;
  logic         bad_enc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vec_narrow_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .vlen_sel(vlen_sel), .mode(mode), .mask(mask), .mask_en(mask_en),
    .zero_mask(zero_mask), .dest_mem(dest_mem), .old_dest(old_dest),
    .rsvd_field(rsvd_field), .out_valid(out_valid), .result(result),
    .byte_en(byte_en), .bad_enc(bad_enc)
  );

  function automatic logic [15:0] ref_word(input logic [31:0] v, input logic [1:0] m);
    longint sv, uv;
    sv = longint'($signed(v));
    uv = longint'({32'b0, v});
    case (m)
      2'b01: ref_word = (sv > 32767) ? 16'h7FFF : (sv < -32768) ? 16'h8000 : v[15:0];
      2'b10: ref_word = (uv > 65535) ? 16'hFFFF : v[15:0];
      default: ref_word = v[15:0];
    endcase
  endfunction

  task automatic ref_model(output logic [511:0] er, output logic [31:0] eb, output logic ebad);
    int kl;
    logic en;
    er = '0; eb = '0;
    ebad = (rsvd_field != 4'hF) || (mode == 2'b11) || (vlen_sel == 2'b11);
    if (ebad) return;
    kl = (vlen_sel == 2'b00) ? 4 : (vlen_sel == 2'b01) ? 8 : 16;
    if (dest_mem) er = old_dest;
    for (int j = 0; j < 16; j++) begin
      if (j < kl) begin
        en = !mask_en || mask[j];
        if (en) begin
          er[16*j +: 16] = ref_word(src[32*j +: 32], mode);
          if (dest_mem) eb[2*j +: 2] = 2'b11;
        end else if (!dest_mem && !zero_mask)
          er[16*j +: 16] = old_dest[16*j +: 16];
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, then compare all outputs against the model
  task automatic run_op(input string req);
    logic [511:0] er; logic [31:0] eb; logic eb_bad;
    ref_model(er, eb, eb_bad);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " R11 out_valid"}, {511'b0, out_valid}, 512'd1);
    check(result === er, {req, " result"}, result, er);
    check(byte_en === eb, {req, " byte_en"}, {480'b0, byte_en}, {480'b0, eb});
    check(bad_enc === eb_bad, {req, " bad_enc"}, {511'b0, bad_enc}, {511'b0, eb_bad});
  endtask

  function automatic logic [31:0] biased_val();
    case ($urandom_range(0, 7))
      0: biased_val = 32'd32767 + $urandom_range(0, 2);
      1: biased_val = 32'hFFFF8000 - $urandom_range(0, 2);
      2: biased_val = 32'd65535 + $urandom_range(0, 2);
      3: biased_val = $urandom_range(0, 65535);
      4: biased_val = 32'hFFFFFFFF - $urandom_range(0, 3);
      default: biased_val = $urandom;
    endcase
  endfunction

  task automatic fill_old();
    for (int k = 0; k < 16; k++) old_dest[32*k +: 32] = $urandom;
  endtask

  initial begin
    logic [511:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && result === '0 && byte_en === '0 && bad_enc === 1'b0,
          "R11 reset state", result, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R2 truncation, full length, register dest
    fill_old();
    for (int k = 0; k < 16; k++) src[32*k +: 32] = 32'hA5A50000 | k;
    vlen_sel = 2'b10; mode = 2'b00; mask_en = 1'b0; dest_mem = 1'b0;
    run_op("R3 R2 truncate");

    // R4 signed thresholds
    src[31:0] = 32'd32767; src[63:32] = 32'd32768; src[95:64] = 32'hFFFF8000; src[127:96] = 32'hFFFF7FFF;
    vlen_sel = 2'b00; mode = 2'b01;
    run_op("R4 R1 signed saturate 128");

    // R5 unsigned thresholds
    src[31:0] = 32'd65535; src[63:32] = 32'd65536; src[95:64] = 32'hFFFFFFFF; src[127:96] = 32'd7;
    mode = 2'b10;
    run_op("R5 unsigned saturate");

    // R6 merging and zeroing on register dest, R7 upper clear
    vlen_sel = 2'b01; mode = 2'b00; mask_en = 1'b1; mask = 16'h00A5; zero_mask = 1'b0;
    run_op("R6 R7 merge register");
    zero_mask = 1'b1;
    run_op("R6 R7 zero register");

    // R8 memory ignores zeroing
    dest_mem = 1'b1;
    run_op("R8 memory merge");

    // R10 mask bits above KL ignored
    vlen_sel = 2'b00; dest_mem = 1'b0; mask = 16'hFFF0; zero_mask = 1'b1;
    run_op("R10 high mask bits register");
    dest_mem = 1'b1;
    run_op("R10 high mask bits memory");

    // R9 invalid encodings
    dest_mem = 1'b1; rsvd_field = 4'b1110;
    run_op("R9 reserved field");
    rsvd_field = 4'hF; mode = 2'b11;
    run_op("R9 mode code");
    mode = 2'b00; vlen_sel = 2'b11;
    run_op("R9 R1 length code");
    vlen_sel = 2'b10;

    // R11 hold when idle
    run_op("R11 setup");
    held = result;
    fill_old(); src = ~src; mode = 2'b01;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid low when idle", {511'b0, out_valid}, 512'd0);
    check(result === held, "R11 result holds when idle", result, held);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 16; k++) src[32*k +: 32] = biased_val();
      fill_old();
      vlen_sel   = ($urandom_range(0, 19) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      mode       = ($urandom_range(0, 19) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      rsvd_field = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      mask       = 16'($urandom);
      mask_en    = 1'($urandom);
      zero_mask  = 1'($urandom);
      dest_mem   = 1'($urandom);
      run_op("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule